// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This controller sits between a set of interrupt request lines and a processor core that has only one interrupt input. A rising edge on any request line latches a pending flag for that channel. Each channel has an enable bit and a handler-address register that software can program. The controller finds the most urgent channel that is pending and enabled, raises a single interrupt line, and gives the core that channel's handler address and index.

When the core accepts the interrupt, it pulses an acknowledge input. The controller then records the selected channel as in service. While a channel is in service, only a strictly more urgent channel can raise the interrupt line again. This lets handlers nest by priority. Requests from that channel or from less urgent ones stay pending and do not pulse the line. Software clears pending flags by writing ones to them. It ends service by writing to the in-service register, which retires the most urgent in-service channel.

Software reaches all state through a plain register port that has a select, a write enable, a byte address and a combinational read path.

Top module: `pic_vectored_irq`

## Requirements
- R1: After a synchronous active-low reset, the interrupt line is low, `irq_vector_o` is 0, and the pending, enable, in-service and handler-address registers all read 0.
- R2: A 0-to-1 transition on `irq_req_i[n]`, seen between two clock edges, sets pending bit n on the second edge. A line held high sets the bit only once. After software clears the bit, it stays clear until a new rising edge.
- R3: Pending bits are at byte offset 0x20, bit n for channel n. A write of 1 clears a bit and a write of 0 leaves it unchanged. If a rising edge and a clear for the same channel arrive in the same cycle, the bit ends up set.
- R4: The handler-address register of channel n is at byte offset 4*n. It is read/write and 32 bits wide.
- R5: The enable mask is at byte offset 0x24, bit n for channel n. It is read/write. A channel whose enable bit is 0 can still become pending, but it never raises `irq_o`.
- R6: `irq_o` is high when at least one channel is pending, enabled and more urgent than every in-service channel. A lower index means more urgent. While `irq_o` is high, `irq_chan_o` is the lowest such index and `irq_vector_o` is that channel's handler address. While `irq_o` is low, `irq_vector_o` is 0.
- R7: A cycle with `irq_ack_i` high while `irq_o` is high sets the in-service bit of the channel on `irq_chan_o`. Reading byte offset 0x28 returns the in-service bits, bit n for channel n.
- R8: While a channel is in service, pending requests from the same channel or any higher-indexed channel keep `irq_o` low.
- R9: While a channel is in service, a pending, enabled request from a lower-indexed channel raises `irq_o`. An acknowledge then adds that channel to the in-service set.
- R10: Any write to byte offset 0x28 clears only the lowest-indexed in-service bit. Once all in-service bits are clear, a blocked pending channel can raise `irq_o` again.
- R11: Byte offsets from 0x2C to 0x3F read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | NUM_CH | Request lines, synchronous to clk |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as the strobe |
| irq_o | output | 1 | Interrupt line to the core |
| irq_ack_i | input | 1 | Core accepted the interrupt shown on the outputs |
| irq_vector_o | output | VEC_W | Handler address of the selected channel |
| irq_chan_o | output | IDX_W | Index of the selected channel |

## Verification
The assertions assume three things about the inputs: the core pulses `irq_ack_i` only in cycles where `irq_o` is high, request lines are already synchronous to `clk`, and register writes are single-cycle strobes. The bench keeps to these assumptions. It raises the acknowledge only on steps that follow a check showing the interrupt line high. It changes request lines and strobes only on the falling clock edge. It holds the request lines low while reset is released, so no edge is latched before software starts.

// File: rtl/pic_pkg.sv
// Shared definitions for the prioritised vectored interrupt controller.
// Assumes register words are 4 bytes apart and that status registers
// follow directly after the handler-address registers.
package pic_pkg;

    // Register classes decoded from the word index on the bus.
    typedef enum logic [2:0] {
        REG_VEC  = 3'd0,
        REG_PEND = 3'd1,
        REG_EN   = 3'd2,
        REG_SVC  = 3'd3,
        REG_NONE = 3'd4
    } reg_kind_e;

    // Number of status words that follow the handler-address words.
    localparam int STATUS_WORDS = 3;

    // Classify a word index given the channel count.
    function automatic reg_kind_e classify(input int word, input int num_ch);
        if (word < num_ch)
            return REG_VEC;
        else if (word == num_ch)
            return REG_PEND;
        else if (word == num_ch + 1)
            return REG_EN;
        else if (word == num_ch + 2)
            return REG_SVC;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/pic_edge_capture.sv
// Turns request lines into sticky pending flags.
// Assumes the request lines are already synchronous to clk. A line that is
// high when reset is released counts as one rising edge.
module pic_edge_capture #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] pending_o
);

    logic [NUM_CH-1:0] prev_q;
    logic [NUM_CH-1:0] pending_q;
    logic [NUM_CH-1:0] rise;

    // Detect a 0-to-1 change against the previous sample.
    always_comb begin
        rise = req_i & ~prev_q;
    end

    // Remember the last sample of the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= req_i;
    end

    // Set on a rising edge and clear on a software write; a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= '0;
        else
            pending_q <= (pending_q & ~clr_i) | rise;
    end

    assign pending_o = pending_q;

    // R2: a flag drops only when software asked for it.
    a_r2_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pending_q) & ~$past(clr_i) & ~pending_q) == '0));

    // R3: a cleared flag stays clear unless an edge came in the same cycle.
    a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pending_q & $past(clr_i) & ~$past(req_i & ~prev_q)) == '0));

endmodule

// File: rtl/pic_prio_select.sv
// Chooses the most urgent channel that may interrupt now.
// A channel qualifies when it is pending and enabled and no channel with the
// same or a lower index is in service. Index 0 is the most urgent. Purely
// combinational.
module pic_prio_select #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_CH-1:0] pending_i,
    input  logic [NUM_CH-1:0] enable_i,
    input  logic [NUM_CH-1:0] in_service_i,
    output logic              valid_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [NUM_CH-1:0] allowed;
    logic [NUM_CH-1:0] cand;

    // Build the mask of channels strictly more urgent than any in service.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            blocked    = blocked | in_service_i[i];
            allowed[i] = ~blocked;
        end
    end

    // Pick the lowest qualifying index.
    always_comb begin
        cand  = pending_i & enable_i & allowed;
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i])
                idx_o = IDX_W'(i);
        end
        valid_o = |cand;
    end

endmodule

// File: rtl/pic_service_tracker.sv
// Keeps the set of channels whose handlers are running.
// An acknowledge adds the selected channel. An end-of-service strobe removes
// the lowest-indexed member. Assumes an acknowledge only while a channel is
// selected.
module pic_service_tracker #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic              valid_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic              eoi_i,
    output logic [NUM_CH-1:0] in_service_o
);

    logic [NUM_CH-1:0] in_service_q;
    logic [NUM_CH-1:0] lowest;
    logic [NUM_CH-1:0] add_mask;
    logic              take;

    // Isolate the most urgent in-service bit and form the entry mask.
    always_comb begin
        lowest   = in_service_q & (~in_service_q + NUM_CH'(1));
        take     = ack_i & valid_i;
        add_mask = '0;
        if (take)
            add_mask[sel_i] = 1'b1;
    end

    // Retire one level on end of service and enter one on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_service_q <= '0;
        else
            in_service_q <= (in_service_q & ~(eoi_i ? lowest : '0)) | add_mask;
    end

    assign in_service_o = in_service_q;

    // R7: an accepted interrupt marks its channel as in service.
    a_r7_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && valid_i) |=> in_service_q[$past(sel_i)]);

    // R10: end of service alone retires exactly one level if any is active.
    a_r10_eoi_single_level: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && valid_i)) |=>
            ($countones(in_service_q) ==
             $countones($past(in_service_q)) - int'(|$past(in_service_q))));

endmodule

// File: rtl/pic_regfile.sv
// Software-visible registers: per-channel handler addresses, the enable mask,
// and the decode of pending-clear and end-of-service writes. The read path is
// combinational. Assumes VEC_W and NUM_CH do not exceed DATA_W.
module pic_regfile
    import pic_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3,
    parameter int VEC_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NUM_CH-1:0] pending_i,
    input  logic [NUM_CH-1:0] in_service_i,
    input  logic [IDX_W-1:0]  sel_i,
    output logic [NUM_CH-1:0] enable_o,
    output logic [NUM_CH-1:0] clr_o,
    output logic              eoi_o,
    output logic [VEC_W-1:0]  sel_vector_o
);

    localparam int WI = ADDR_W - 2;

    logic [WI-1:0]     word_idx;
    reg_kind_e         kind;
    logic              wr_en;
    logic [NUM_CH-1:0] enable_q;
    logic [VEC_W-1:0]  vec_q [NUM_CH];

    // Decode the word index into a register class.
    always_comb begin
        word_idx = bus_addr_i[ADDR_W-1:2];
        kind     = classify(int'(word_idx), NUM_CH);
        wr_en    = bus_sel_i & bus_we_i;
    end

    // One handler-address register per channel.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_vec
        // Load the handler address when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vec_q[n] <= '0;
            else if (wr_en && kind == REG_VEC && word_idx == WI'(n))
                vec_q[n] <= bus_wdata_i[VEC_W-1:0];
        end
    end

    // Hold the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (wr_en && kind == REG_EN)
            enable_q <= bus_wdata_i[NUM_CH-1:0];
    end

    // Produce the write-one-to-clear mask and the end-of-service strobe.
    always_comb begin
        clr_o = (wr_en && kind == REG_PEND) ? bus_wdata_i[NUM_CH-1:0] : '0;
        eoi_o = wr_en && kind == REG_SVC;
    end

    // Combinational read multiplexer; unmapped words read zero.
    always_comb begin
        bus_rdata_o = '0;
        case (kind)
            REG_VEC:  bus_rdata_o[VEC_W-1:0]  = vec_q[word_idx[IDX_W-1:0]];
            REG_PEND: bus_rdata_o[NUM_CH-1:0] = pending_i;
            REG_EN:   bus_rdata_o[NUM_CH-1:0] = enable_q;
            REG_SVC:  bus_rdata_o[NUM_CH-1:0] = in_service_i;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign enable_o     = enable_q;
    assign sel_vector_o = vec_q[sel_i];

    // R11: a write to an unmapped word leaves the enable mask alone.
    a_r11_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_NONE) |=> $stable(enable_q));

    // R5: a write to the enable word is visible on the next cycle.
    a_r5_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_EN) |=> (enable_q == $past(bus_wdata_i[NUM_CH-1:0])));

endmodule

// File: rtl/pic_vectored_irq.sv
// Top of the prioritised vectored interrupt controller.
// It latches request edges and selects the most urgent pending, enabled
// channel above the current service level. It drives one interrupt line with
// that channel's handler address and tracks nested service levels.
// Assumes irq_ack_i is pulsed only while irq_o is high.
module pic_vectored_irq #(
    parameter int NUM_CH = 8,
    parameter int VEC_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_req_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    input  logic              irq_ack_i,
    output logic [VEC_W-1:0]  irq_vector_o,
    output logic [IDX_W-1:0]  irq_chan_o
);

    logic [NUM_CH-1:0] pending;
    logic [NUM_CH-1:0] enable;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] in_service;
    logic              eoi;
    logic              sel_valid;
    logic [IDX_W-1:0]  sel_idx;
    logic [VEC_W-1:0]  sel_vector;

    pic_edge_capture #(
        .NUM_CH (NUM_CH)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (irq_req_i),
        .clr_i     (clr_mask),
        .pending_o (pending)
    );

    pic_prio_select #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_select (
        .pending_i    (pending),
        .enable_i     (enable),
        .in_service_i (in_service),
        .valid_o      (sel_valid),
        .idx_o        (sel_idx)
    );

    pic_service_tracker #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_service (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_i        (irq_ack_i),
        .valid_i      (sel_valid),
        .sel_i        (sel_idx),
        .eoi_i        (eoi),
        .in_service_o (in_service)
    );

    pic_regfile #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W),
        .VEC_W  (VEC_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel_i    (bus_sel_i),
        .bus_we_i     (bus_we_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .pending_i    (pending),
        .in_service_i (in_service),
        .sel_i        (sel_idx),
        .enable_o     (enable),
        .clr_o        (clr_mask),
        .eoi_o        (eoi),
        .sel_vector_o (sel_vector)
    );

    // Drive the core-facing outputs; the vector is zero when idle.
    always_comb begin
        irq_o        = sel_valid;
        irq_chan_o   = sel_idx;
        irq_vector_o = sel_valid ? sel_vector : '0;
    end

    // Channels at or below the shown index, used only by the checks below.
    logic [NUM_CH-1:0] upto_chan;
    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            upto_chan[i] = (IDX_W'(i) <= irq_chan_o);
    end

    // R6: the shown channel is both pending and enabled.
    a_r6_source_pending_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pending[irq_chan_o] && enable[irq_chan_o]));

    // R8: no interrupt at or below the most urgent in-service level.
    a_r8_no_lower_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((in_service & upto_chan) == '0));

    // R6: the vector is zero whenever the line is low.
    a_r6_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_vector_o == '0));

endmodule

// File: tb/pic_vectored_irq_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset and corner cases.
module pic_vectored_irq_tb;

    localparam int NUM_CH = 8;
    localparam int VEC_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 3;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_REQ = 3'd2;
    localparam logic [2:0] OP_ACK = 3'd3;
    localparam logic [2:0] OP_IRQ = 3'd4;

    // exp for OP_IRQ: bit 8 = line, bits 2:0 = channel; data = vector.
    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  rq;
    } step_t;

    localparam int NSTEPS = 36;
    localparam step_t STEPS [NSTEPS] = '{
        '{OP_WR,  6'h00, 32'h100, 32'h0,   4'd4},  // R4
        '{OP_WR,  6'h08, 32'h120, 32'h0,   4'd4},  // R4
        '{OP_WR,  6'h14, 32'h150, 32'h0,   4'd4},  // R4
        '{OP_RD,  6'h08, 32'h0,   32'h120, 4'd4},  // R4
        '{OP_RD,  6'h14, 32'h0,   32'h150, 4'd4},  // R4
        '{OP_RD,  6'h20, 32'h0,   32'h0,   4'd1},  // R1
        '{OP_REQ, 6'h00, 32'h20,  32'h0,   4'd2},  // R2 ch5 rises
        '{OP_RD,  6'h20, 32'h0,   32'h20,  4'd2},  // R2
        '{OP_IRQ, 6'h00, 32'h0,   32'h0,   4'd5},  // R5 masked
        '{OP_WR,  6'h24, 32'hFF,  32'h0,   4'd5},  // R5
        '{OP_RD,  6'h24, 32'h0,   32'hFF,  4'd5},  // R5
        '{OP_IRQ, 6'h00, 32'h150, 32'h105, 4'd6},  // R6 ch5
        '{OP_ACK, 6'h00, 32'h0,   32'h0,   4'd7},  // R7
        '{OP_RD,  6'h28, 32'h0,   32'h20,  4'd7},  // R7
        '{OP_IRQ, 6'h00, 32'h0,   32'h0,   4'd8},  // R8 same channel pending
        '{OP_WR,  6'h20, 32'h20,  32'h0,   4'd3},  // R3
        '{OP_RD,  6'h20, 32'h0,   32'h0,   4'd3},  // R3
        '{OP_REQ, 6'h00, 32'h80,  32'h0,   4'd8},  // R8 ch7 rises
        '{OP_IRQ, 6'h00, 32'h0,   32'h0,   4'd8},  // R8
        '{OP_RD,  6'h20, 32'h0,   32'h80,  4'd8},  // R8
        '{OP_REQ, 6'h00, 32'h84,  32'h0,   4'd9},  // R9 ch2 rises
        '{OP_IRQ, 6'h00, 32'h120, 32'h102, 4'd9},  // R9
        '{OP_ACK, 6'h00, 32'h0,   32'h0,   4'd9},  // R9
        '{OP_RD,  6'h28, 32'h0,   32'h24,  4'd9},  // R9
        '{OP_IRQ, 6'h00, 32'h0,   32'h0,   4'd8},  // R8
        '{OP_WR,  6'h20, 32'h04,  32'h0,   4'd3},  // R3
        '{OP_WR,  6'h28, 32'h0,   32'h0,   4'd10}, // R10
        '{OP_RD,  6'h28, 32'h0,   32'h20,  4'd10}, // R10
        '{OP_IRQ, 6'h00, 32'h0,   32'h0,   4'd10}, // R10
        '{OP_WR,  6'h28, 32'h0,   32'h0,   4'd10}, // R10
        '{OP_RD,  6'h28, 32'h0,   32'h0,   4'd10}, // R10
        '{OP_IRQ, 6'h00, 32'h0,   32'h107, 4'd10}, // R10 ch7 vector 0
        '{OP_RD,  6'h2C, 32'h0,   32'h0,   4'd11}, // R11
        '{OP_WR,  6'h3C, 32'h0,   32'h0,   4'd11}, // R11
        '{OP_RD,  6'h24, 32'h0,   32'hFF,  4'd11}, // R11
        '{OP_RD,  6'h20, 32'h0,   32'h80,  4'd3}   // R3
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NUM_CH-1:0] irq_req;
    logic              bus_sel;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic              irq_ack;
    logic [VEC_W-1:0]  irq_vector;
    logic [IDX_W-1:0]  irq_chan;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pic_vectored_irq #(
        .NUM_CH (NUM_CH),
        .VEC_W  (VEC_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_req_i    (irq_req),
        .bus_sel_i    (bus_sel),
        .bus_we_i     (bus_we),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .irq_o        (irq),
        .irq_ack_i    (irq_ack),
        .irq_vector_o (irq_vector),
        .irq_chan_o   (irq_chan)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Start a new cycle at the falling edge with all strobes idle.
    task automatic idle_cycle();
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
        irq_ack = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        idle_cycle();
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        idle_cycle();
        bus_sel  = 1'b1;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, e);
    endtask

    task automatic irq_chk(input logic [31:0] e, input logic [31:0] vec, input string tag);
        idle_cycle();
        #1;
        check({tag, " line"}, {31'b0, irq}, {31'b0, e[8]});
        if (e[8]) begin
            check({tag, " chan"}, {29'b0, irq_chan}, {29'b0, e[2:0]});
            check({tag, " vector"}, irq_vector, vec);
        end else begin
            check({tag, " idle vector"}, irq_vector, 32'h0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        irq_req   = '0;
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        irq_ack   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: state straight after reset.
        irq_chk(32'h0, 32'h0, "R1 reset irq");
        rd(6'h24, 32'h0, "R1 reset enable");
        rd(6'h28, 32'h0, "R1 reset in-service");
        rd(6'h00, 32'h0, "R1 reset vector0");

        // Walk the vector table.
        for (int s = 0; s < NSTEPS; s++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", STEPS[s].rq, s);
            case (STEPS[s].op)
                OP_WR:  wr(STEPS[s].addr, STEPS[s].data);
                OP_RD:  rd(STEPS[s].addr, STEPS[s].exp, tag);
                OP_REQ: begin
                    idle_cycle();
                    irq_req = STEPS[s].data[NUM_CH-1:0];
                end
                OP_ACK: begin
                    idle_cycle();
                    irq_ack = 1'b1;
                end
                default: irq_chk(STEPS[s].exp, STEPS[s].data, tag);
            endcase
        end

        // R3: an edge and a clear of the same channel in one cycle; the edge wins.
        idle_cycle();
        irq_req = 8'h00;
        wr(6'h20, 32'h81);
        irq_req = 8'h01;
        rd(6'h20, 32'h01, "R3 edge beats clear");

        // R2: a line held high does not set the flag again after a clear.
        wr(6'h20, 32'h01);
        idle_cycle();
        rd(6'h20, 32'h00, "R2 held level no repeat");

        // R6: all lines rise together; the lowest index is chosen.
        idle_cycle();
        irq_req = 8'h00;
        idle_cycle();
        irq_req = 8'hFF;
        rd(6'h20, 32'hFF, "R6 all pending");
        irq_chk(32'h100, 32'h100, "R6 lowest index wins");

        // R5: disabling channel 0 hands the line to the next channel (ch1 vector 0).
        wr(6'h24, 32'hFE);
        irq_chk(32'h101, 32'h0, "R5 mask skips ch0");

        // R1: reset again in the middle of activity.
        idle_cycle();
        irq_req = 8'h00;
        rst_n   = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        irq_chk(32'h0, 32'h0, "R1 re-reset irq");
        rd(6'h20, 32'h0, "R1 re-reset pending");
        rd(6'h24, 32'h0, "R1 re-reset enable");
        rd(6'h08, 32'h0, "R1 re-reset vector2");

        idle_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule